// File: doc/BRIEF.md
# Prescaled Programmable Interval Timer

This block produces a periodic "interval done" event from a free-running oscillator. A prescaler counts oscillator cycles and wraps every 2^PRESC_W cycles. The interval logic acts only at those wraps. Software writes an interval expressed in raw oscillator cycles. The block converts that value into a whole number of prescaler wraps, always rounding up, and counts it down. At each expiry it sets a sticky done flag. The flag drives an interrupt request only while the interrupt enable is high.

A new interval is held aside until the interval in progress finishes, so the running period is never cut short. Writing an interval does not disturb the prescaler phase. The first expiry after a write from idle can therefore land up to one prescaler period later than the nominal length. The top bit of the interval word is a sign position. The block ignores it and reads it back as zero.

Top module: `intv_timer`

## Requirements
- R1: The interval counter changes state only on a prescaler wrap, which occurs once every 2^PRESC_W oscillator cycles. With PRESC_W=4, wraps fall on oscillator cycles 16, 32, 48 and so on, counted from release of reset.
- R2: The period in wraps equals write-data bits [INTV_W-2:PRESC_W], plus one when any of bits [PRESC_W-1:0] is non-zero. For example, with PRESC_W=4 a write of 17 gives 2 wraps and a write of 48 gives 3 wraps.
- R3: Each expiry sets doneFlag one cycle after the expiring wrap. Expiries then repeat every period times 2^PRESC_W cycles for as long as the period is unchanged.
- R4: irq is high exactly when doneFlag and intEn are both high.
- R5: doneFlag stays set until a cycle with clrFlag high, which clears it on the next edge. An expiry in the same cycle as clrFlag leaves the flag set.
- R6: A write from idle does not restart the prescaler. The counter loads the new period at the first wrap strictly after the write cycle, and the first expiry follows that many wraps later.
- R7: A write while an interval is running changes only the pending period. The running interval finishes with its old length, and the new period applies from that expiry on.
- R8: rdData returns the last written word with bit INTV_W-1 forced to zero. That bit has no effect on the period.
- R9: After reset, doneFlag, irq and rdData are zero, and no expiry occurs until a non-zero interval is written. Writing zero stops expiries after the interval in progress ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Interval write strobe |
| wrData | input | INTV_W | Interval in raw oscillator cycles |
| rdData | output | INTV_W | Last written interval, top bit cleared |
| clrFlag | input | 1 | Clears the done flag |
| intEn | input | 1 | Interrupt enable for the done flag |
| doneFlag | output | 1 | Sticky interval-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle. It confirms that the flag sets after each internal expiry and holds until cleared, and that a clear without a simultaneous expiry drops it. It also checks that irq follows the flag gated by the enable, and that readback matches the last write with the sign bit masked. Exact expiry timing cannot be checked cycle by cycle. This covers the round-up of partial periods, the prescaler phase at load, the deferral of a rewritten period until the running interval ends, and the halt after writing zero. Those timings appear only when the bench's scoreboard compares each observed flag against the oscillator cycle it predicted.

// File: rtl/intv_pkg.sv
package intv_pkg;
  // strobes issued by the control to the datapath on a prescaler wrap
  typedef struct packed {
    logic reload;   // load counter from pending period
    logic dec;      // decrement the running counter
    logic expire;   // interval has ended on this wrap
  } intvStb_t;
endpackage

// File: rtl/intv_ctrl.sv
module intv_ctrl
  import intv_pkg::*;
#(
  parameter int PRESC_W = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cntZero,
  input  logic     cntOne,
  input  logic     clrFlag,
  input  logic     intEn,
  output intvStb_t stb,
  output logic     doneFlag,
  output logic     irq
);
  logic [PRESC_W-1:0] psc;
  logic               pscWrap;

  // free-running prescaler, never touched by writes
  always_ff @(posedge clk) begin
    if (!rst_n) psc <= '0;
    else        psc <= psc + 1'b1;
  end

  assign pscWrap = &psc;

  always_comb begin
    stb        = '0;
    stb.expire = pscWrap && cntOne;
    stb.reload = pscWrap && (cntOne || cntZero);
    stb.dec    = pscWrap && !cntOne && !cntZero;
  end

  // sticky flag, a new expiry wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n)          doneFlag <= 1'b0;
    else if (stb.expire) doneFlag <= 1'b1;
    else if (clrFlag)    doneFlag <= 1'b0;
  end

  assign irq = doneFlag & intEn;
endmodule

// File: rtl/intv_dp.sv
module intv_dp
  import intv_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int INTV_W  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [INTV_W-1:0] wrData,
  input  intvStb_t          stb,
  output logic [INTV_W-1:0] rdData,
  output logic              cntZero,
  output logic              cntOne
);
  localparam int CNT_W = INTV_W - PRESC_W;  // magnitude bits plus round-up carry

  logic [INTV_W-2:0] intvReg;
  logic [CNT_W-1:0]  pendPeriod;
  logic [CNT_W-1:0]  wrPeriod;
  logic [CNT_W-1:0]  count;
  logic              unusedBits;

  assign unusedBits = wrData[INTV_W-1] ^ stb.expire;

  // round a raw cycle count up to whole prescaler wraps
  assign wrPeriod = {1'b0, wrData[INTV_W-2:PRESC_W]}
                  + CNT_W'(|wrData[PRESC_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intvReg    <= '0;
      pendPeriod <= '0;
    end else if (wrEn) begin
      intvReg    <= wrData[INTV_W-2:0];
      pendPeriod <= wrPeriod;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (stb.reload) count <= pendPeriod;
    else if (stb.dec)    count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
  assign cntOne  = (count == CNT_W'(1));
  assign rdData  = {1'b0, intvReg};
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int INTV_W  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [INTV_W-1:0] wrData,
  output logic [INTV_W-1:0] rdData,
  input  logic              clrFlag,
  input  logic              intEn,
  output logic              doneFlag,
  output logic              irq
);
  intvStb_t stb;
  logic     cntZero;
  logic     cntOne;

  intv_ctrl #(.PRESC_W(PRESC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cntZero(cntZero), .cntOne(cntOne),
    .clrFlag(clrFlag), .intEn(intEn), .stb(stb),
    .doneFlag(doneFlag), .irq(irq)
  );

  intv_dp #(.PRESC_W(PRESC_W), .INTV_W(INTV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .stb(stb), .rdData(rdData), .cntZero(cntZero), .cntOne(cntOne)
  );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int INTV_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [INTV_W-1:0] wrData,
  input logic [INTV_W-1:0] rdData,
  input logic              clrFlag,
  input logic              intEn,
  input logic              doneFlag,
  input logic              irq,
  input logic              expire
);
  a_r3_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> doneFlag);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    doneFlag && !clrFlag |=> doneFlag);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clrFlag && !expire |=> !doneFlag);

  a_r9_rise_needs_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(expire));

  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !intEn |-> !irq);

  a_r4_irq_passed: assert property (@(posedge clk) disable iff (!rst_n)
    doneFlag && intEn |-> irq);

  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> rdData == {1'b0, $past(wrData[INTV_W-2:0])});

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(rdData));
endmodule

bind intv_timer intv_timer_chk #(.INTV_W(INTV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .clrFlag(clrFlag), .intEn(intEn),
  .doneFlag(doneFlag), .irq(irq), .expire(stb.expire)
);

// File: tb/sim_intv_timer.sv
`timescale 1ns/1ps
module sim_intv_timer;
  localparam int PW = 4;
  localparam int IW = 36;
  localparam int TK = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrData = '0;
  logic          clrFlag = 1'b0;
  logic          intEn = 1'b0;
  logic [IW-1:0] rdData;
  logic          doneFlag;
  logic          irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int expQ[$];
  bit autoClr = 1'b1;
  bit clrReq = 1'b0;

  always #2.5 clk = ~clk;

  intv_timer #(.PRESC_W(PW), .INTV_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clrFlag(clrFlag), .intEn(intEn),
    .doneFlag(doneFlag), .irq(irq)
  );

  // oscillator edges counted since reset release
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops the expected expiry cycle for each flag it sees
  always @(negedge clk) begin
    if (rst_n) begin
      if (clrFlag) clrFlag = 1'b0;
      else if (clrReq) begin clrFlag = 1'b1; clrReq = 1'b0; end
      else if (doneFlag && autoClr) begin
        if (expQ.size() == 0) chk("R3 unexpected expiry", cyc, -1);
        else chk("R3 expiry cycle", cyc, expQ.pop_front());
        clrFlag = 1'b1;
      end
    end
  end

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver: write, return the edge that captures it
  task automatic doWrite(input logic [IW-1:0] v, output int w);
    @(negedge clk);
    wrData = v; wrEn = 1'b1; w = cyc + 1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    int w, wl, base;
    repeat (3) @(negedge clk);
    chk("R9 reset flag", doneFlag, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset rdData", rdData, 0);
    rst_n = 1'b1;

    // idle: no expiry without an interval (R9), monitor catches any
    waitCyc(5 * TK + 3);
    chk("R9 idle no flag", doneFlag, 0);

    // exact multiple, 3 wraps (R1, R6)
    doWrite(IW'(3 * TK), w);
    chk("R8 readback", rdData, 3 * TK);
    wl = (w / TK + 1) * TK;
    expQ.push_back(wl + 3 * TK);
    expQ.push_back(wl + 6 * TK);
    waitCyc(wl + 6 * TK + 2);
    chk("R6 R3 queue drained", expQ.size(), 0);

    // rewrite mid-interval with 17 cycles -> 2 wraps (R2, R7)
    doWrite(IW'(TK + 1), w);
    chk("R8 readback 2", rdData, TK + 1);
    expQ.push_back(wl + 9 * TK);
    expQ.push_back(wl + 11 * TK);
    expQ.push_back(wl + 13 * TK);
    waitCyc(wl + 13 * TK + 2);
    chk("R7 R2 queue drained", expQ.size(), 0);

    // sign bit set, period 1 wrap (R8)
    doWrite({1'b1, 35'(TK)}, w);
    chk("R8 sign masked", rdData, TK);
    expQ.push_back(wl + 15 * TK);
    expQ.push_back(wl + 16 * TK);
    expQ.push_back(wl + 17 * TK);
    waitCyc(wl + 17 * TK + 2);

    // zero stops after the running interval (R9)
    doWrite('0, w);
    expQ.push_back(wl + 18 * TK);
    waitCyc(wl + 25 * TK);
    chk("R9 stop queue drained", expQ.size(), 0);
    chk("R9 stopped flag", doneFlag, 0);

    // sticky flag and irq gating (R4, R5)
    autoClr = 1'b0;
    doWrite(IW'(TK), w);
    base = (w / TK + 1) * TK + TK;
    waitCyc(base);
    chk("R3 flag set", doneFlag, 1);
    chk("R4 irq masked", irq, 0);
    intEn = 1'b1;
    @(negedge clk);
    chk("R4 irq raised", irq, 1);
    waitCyc(base + 3 * TK + TK / 2);
    chk("R5 flag sticky", doneFlag, 1);
    clrReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 flag cleared", doneFlag, 0);
    chk("R4 irq dropped", irq, 0);
    doWrite('0, w);
    summary();
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule